// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Host Controller

This block is the host-side master for a byte-wide parallel EEPROM that has a static-RAM-like bus: an address bus, chip-enable, write-enable and output-enable strobes (all active low), and a shared data bus. A client issues single-byte read or write commands through a valid/ready handshake. The controller drives the bus pins with cycle counts derived from nanosecond timing parameters and the clock period. Every nanosecond value is rounded up to whole cycles, with a minimum of one cycle.

A read drives the address with chip-enable and output-enable low. It waits the longer of the address access time and the output-enable access time, samples the data bus, and returns the byte. A write has three phases: setup, a write-enable low pulse, then a hold phase in which address and data stay driven. The controller then releases the data bus and polls. It reads the same address over and over and compares data bit 7 with bit 7 of the written byte. While the device is still programming, it returns the inverse of that bit. A match ends the write with a good response. If no match appears within a configurable poll window, the write ends with an error response.

The data bus is split into an output value, an output-enable and an input value, so that the tri-state buffer can sit at the pad level.

Top module: `nvm_byte_host`

## Requirements
- R1: After reset, `cmd_ready` is 1. `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: A write holds `mem_we_n` low for exactly max(ceil(T_WP/CLK), ceil(T_AH/CLK), ceil(T_DS/CLK)) cycles. This is 5 cycles at the default parameters with a 20 ns clock. `mem_addr` does not change while the strobe is low.
- R3: In the cycle before `mem_we_n` falls, `mem_ce_n` is 0, `mem_oe_n` is 1 and `mem_dq_oe` is 1 (address and data are already driven). `mem_oe_n` stays 1 for as long as `mem_we_n` is low.
- R4: After `mem_we_n` rises, address and data stay driven and `mem_oe_n` stays 1 for max(ceil(T_DH), ceil(T_OEH), ceil(T_WPH)) cycles. This is 3 cycles at the defaults. Then `mem_dq_oe` drops.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. In the cycle before every falling edge of `mem_oe_n`, `mem_dq_oe` is 0.
- R6: Every read access, whether a client read or a poll read, holds `mem_oe_n` low with `mem_ce_n` low and a stable address for exactly max(ceil(T_ACC/CLK), ceil(T_OE/CLK)) cycles. This is 8 cycles at the defaults. The byte sampled in the last of those cycles is what the access returns.
- R7: After a write, poll reads of the written address repeat until bit 7 of the sampled byte equals bit 7 of the written byte. The controller then gives a response with `rsp_err` = 0 and `rsp_rdata` equal to that sampled byte.
- R8: If no poll read matches by the time the poll phase has lasted ceil(T_POLL/CLK) cycles, the write ends with `rsp_err` = 1. This response comes no earlier than that many cycles after the command was accepted.
- R9: `cmd_ready` is 1 only while idle. While an access is in progress (`mem_ce_n` = 0), `cmd_ready` is 0 and `cmd_valid` has no effect.
- R10: Each accepted command produces exactly one `rsp_valid` pulse, one cycle long. For a read, `rsp_err` = 0 and `rsp_rdata` is the sampled byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle and able to accept a command |
| cmd_write | input | 1 | 1 = byte write, 0 = byte read |
| cmd_addr | input | ADDR_W (9) | Byte address |
| cmd_wdata | input | DATA_W (8) | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Write poll window expired without a match |
| rsp_rdata | output | DATA_W (8) | Byte read, or final polled byte |
| mem_addr | output | ADDR_W (9) | Device address bus |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_we_n | output | 1 | Device write strobe, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_dq_out | output | DATA_W (8) | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Host drives the data bus when 1 |
| mem_dq_in | input | DATA_W (8) | Value seen on the data bus |

## Verification
The hardest case to reach from the ports is a write that never completes. A real device always finishes programming, so the poll loop only runs out of time if the bench holds its device model busy on purpose. The bench device model has a stuck switch: it freezes the busy countdown, so every poll read of the written address returns the inverted bit 7. With that switch set, the bench checks the error response and its earliest allowed cycle. It then releases the switch and checks, with a later read, that the pending byte was still stored. Poll loops of different lengths come from programming each write with its own busy time, including a one-cycle busy time where the first poll already matches.

// File: rtl/nvm_host_pkg.sv
// Shared types and constant helpers for the parallel EEPROM host controller.
// Assumes all timing parameters are non-negative nanosecond values.
package nvm_host_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_WSET  = 4'd1,
        ST_WLOW  = 4'd2,
        ST_WHOLD = 4'd3,
        ST_PTURN = 4'd4,
        ST_PREAD = 4'd5,
        ST_PEVAL = 4'd6,
        ST_RREAD = 4'd7,
        ST_RESP  = 4'd8
    } host_state_e;

    // Rounds a nanosecond delay up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned cmax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvm_dwell_timer.sv
// Dwell timer: a load of length N makes `expired` read high in the Nth
// cycle after the load edge. Assumes len >= 1 whenever load is high.
module nvm_dwell_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Load the new dwell length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

    p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/nvm_poll_watch.sv
// Read capture and poll supervision: holds the last sampled bus byte,
// compares its top bit with the reference bit, and measures how long the
// poll phase has been running. Assumes `run` stays high for the whole phase.
module nvm_poll_watch #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned TO_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              ref_bit,
    output logic [DATA_W-1:0] sampled,
    output logic              matched,
    output logic              timed_out
);

    localparam int unsigned TW = $clog2(TO_CYC + 1);
    localparam logic [TW-1:0] TO_LIM = TW'(TO_CYC);

    logic [TW-1:0] tcnt;

    // Capture the bus byte at the end of each read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sampled <= '0;
        end else if (sample_en) begin
            sampled <= dq_in;
        end
    end

    // Saturating count of poll-phase cycles; cleared outside the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (!run) begin
            tcnt <= '0;
        end else if (tcnt != TO_LIM) begin
            tcnt <= tcnt + TW'(1);
        end
    end

    assign matched   = (sampled[DATA_W-1] == ref_bit);
    assign timed_out = (tcnt >= TO_LIM);

    p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && timed_out) |=> (!run || timed_out));

endmodule

// File: rtl/nvm_pin_decode.sv
// Decodes the controller state into the device strobes and the data-bus
// output enable. The decode is purely combinational from the state register.
module nvm_pin_decode
    import nvm_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  host_state_e state,
    output logic        ce_n,
    output logic        we_n,
    output logic        oe_n,
    output logic        dq_oe
);

    // Map each state to its pin levels.
    always_comb begin
        ce_n  = 1'b0;
        we_n  = 1'b1;
        oe_n  = 1'b1;
        dq_oe = 1'b0;
        unique case (state)
            ST_WSET, ST_WHOLD: dq_oe = 1'b1;
            ST_WLOW: begin
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_PREAD, ST_RREAD: oe_n = 1'b0;
            ST_PTURN, ST_PEVAL: ;
            default: ce_n = 1'b1;
        endcase
    end

    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_oe && !oe_n));

    p_oe_fall_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> $past(!dq_oe));

    p_strobe_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && !ce_n && dq_oe));

endmodule

// File: rtl/nvm_byte_host.sv
// Host controller for a byte-wide parallel EEPROM with read/compare
// completion polling. It accepts one command at a time and runs the device
// strobes with timings rounded up to clock cycles. A write is finished by
// polling bit 7 of the written address. Assumes the pad logic turns
// mem_dq_out/mem_dq_oe into a tri-state driver and returns the pad as mem_dq_in.
module nvm_byte_host
    import nvm_host_pkg::*;
#(
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_NS    = 20,
    parameter int unsigned T_AS_NS   = 10,
    parameter int unsigned T_AH_NS   = 50,
    parameter int unsigned T_DS_NS   = 50,
    parameter int unsigned T_DH_NS   = 10,
    parameter int unsigned T_WP_NS   = 100,
    parameter int unsigned T_WPH_NS  = 50,
    parameter int unsigned T_OES_NS  = 10,
    parameter int unsigned T_OEH_NS  = 10,
    parameter int unsigned T_ACC_NS  = 150,
    parameter int unsigned T_OE_NS   = 70,
    parameter int unsigned T_POLL_NS = 1200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned SET_CYC  = cmax(ns_to_cyc(T_AS_NS, CLK_NS),
                                            ns_to_cyc(T_OES_NS, CLK_NS));
    localparam int unsigned LOW_CYC  = cmax(ns_to_cyc(T_WP_NS, CLK_NS),
                                       cmax(ns_to_cyc(T_AH_NS, CLK_NS),
                                            ns_to_cyc(T_DS_NS, CLK_NS)));
    localparam int unsigned HOLD_CYC = cmax(ns_to_cyc(T_DH_NS, CLK_NS),
                                       cmax(ns_to_cyc(T_OEH_NS, CLK_NS),
                                            ns_to_cyc(T_WPH_NS, CLK_NS)));
    localparam int unsigned RD_CYC   = cmax(ns_to_cyc(T_ACC_NS, CLK_NS),
                                            ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int unsigned TO_CYC   = ns_to_cyc(T_POLL_NS, CLK_NS);
    localparam int unsigned MAX_DW   = cmax(cmax(SET_CYC, LOW_CYC), cmax(HOLD_CYC, RD_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_DW + 1);

    host_state_e       state, state_n;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              lat_write;
    logic              err_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              expired;
    logic              poll_run;
    logic              sample_en;
    logic              matched;
    logic              timed_out;
    logic [DATA_W-1:0] sampled;

    // Next-state selection for the access sequencer.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (cmd_valid) state_n = cmd_write ? ST_WSET : ST_RREAD;
            ST_WSET:  if (expired) state_n = ST_WLOW;
            ST_WLOW:  if (expired) state_n = ST_WHOLD;
            ST_WHOLD: if (expired) state_n = ST_PTURN;
            ST_PTURN: if (expired) state_n = ST_PREAD;
            ST_PREAD: if (expired) state_n = ST_PEVAL;
            ST_PEVAL: state_n = (matched || timed_out) ? ST_RESP : ST_PREAD;
            ST_RREAD: if (expired) state_n = ST_RESP;
            ST_RESP:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // Dwell length of the state being entered.
    always_comb begin
        unique case (state_n)
            ST_WSET:            tmr_len = CNT_W'(SET_CYC);
            ST_WLOW:            tmr_len = CNT_W'(LOW_CYC);
            ST_WHOLD:           tmr_len = CNT_W'(HOLD_CYC);
            ST_PREAD, ST_RREAD: tmr_len = CNT_W'(RD_CYC);
            default:            tmr_len = CNT_W'(1);
        endcase
    end

    assign tmr_load  = (state_n != state);
    assign poll_run  = (state == ST_PTURN) || (state == ST_PREAD) || (state == ST_PEVAL);
    assign sample_en = ((state == ST_PREAD) || (state == ST_RREAD)) && expired;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Latch the command when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_data  <= '0;
            lat_write <= 1'b0;
        end else if (state == ST_IDLE && cmd_valid) begin
            lat_addr  <= cmd_addr;
            lat_data  <= cmd_wdata;
            lat_write <= cmd_write;
        end
    end

    // Record the outcome of the poll loop; a read never reports an error.
    always_ff @(posedge clk) begin
        if (!rst_n)                  err_q <= 1'b0;
        else if (state == ST_IDLE)   err_q <= 1'b0;
        else if (state == ST_PEVAL)  err_q <= !matched;
    end

    nvm_dwell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (expired)
    );

    nvm_poll_watch #(.DATA_W(DATA_W), .TO_CYC(TO_CYC)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (poll_run),
        .sample_en (sample_en),
        .dq_in     (mem_dq_in),
        .ref_bit   (lat_data[DATA_W-1]),
        .sampled   (sampled),
        .matched   (matched),
        .timed_out (timed_out)
    );

    nvm_pin_decode u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .ce_n  (mem_ce_n),
        .we_n  (mem_we_n),
        .oe_n  (mem_oe_n),
        .dq_oe (mem_dq_oe)
    );

    assign cmd_ready  = (state == ST_IDLE);
    assign rsp_valid  = (state == ST_RESP);
    assign rsp_err    = (state == ST_RESP) && err_q;
    assign rsp_rdata  = sampled;
    assign mem_addr   = lat_addr;
    assign mem_dq_out = lat_data;

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !cmd_ready);

    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_poll_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && lat_write && !rsp_err) |-> (rsp_rdata[DATA_W-1] == lat_data[DATA_W-1]));

    p_read_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !lat_write) |-> !rsp_err);

endmodule

// File: tb/tb_nvm_byte_host.sv
// Scoreboard bench: the driver pushes the expected responses, the monitor
// pops and compares them. A device model answers polls with the inverted
// bit 7 while it is busy.
module tb_nvm_byte_host;

    localparam int CLK_NS   = 20;
    localparam int WE_LOW   = 5;
    localparam int HOLD     = 3;
    localparam int RD       = 8;
    localparam int TO       = 2000;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_write = 1'b0;
    logic [8:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rsp_valid, rsp_err;
    logic [7:0] rsp_rdata;
    logic [8:0] mem_addr;
    logic       mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0] mem_dq_out;
    logic [7:0] mem_dq_in;

    always #(CLK_NS/2) clk = ~clk;

    nvm_byte_host #(.T_POLL_NS(TO * CLK_NS)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int accept_cyc = 0;
    logic [9:0] exp_q[$];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] mem [512];
    logic [7:0] shadow [512];
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    int         busy_cnt = 0;
    int         busy_len = 10;
    logic       stuck = 1'b0;
    logic       prev_we = 1'b1;
    logic       dq_seen = 1'b1;

    always @(negedge clk) begin
        prev_we <= mem_we_n;
        if (!prev_we && mem_we_n) begin
            wr_addr  <= mem_addr;
            wr_data  <= mem_dq_out;
            dq_seen  <= mem_dq_oe;
            busy_cnt <= busy_len;
        end else if (busy_cnt != 0 && !stuck) begin
            busy_cnt <= busy_cnt - 1;
            if (busy_cnt == 1) mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (mem_oe_n || mem_ce_n)                       mem_dq_in = 8'h00;
        else if (busy_cnt != 0 && mem_addr == wr_addr)  mem_dq_in = {~wr_data[7], 7'h15};
        else                                            mem_dq_in = mem[mem_addr];
    end

    // ---------------- monitor ----------------
    logic       p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
    int         we_run = 0, oe_run = 0, hold_run = 0;
    logic       in_hold = 1'b0;
    logic [8:0] strobe_addr = '0;
    int         ready_busy_viol = 0;
    logic [9:0] e;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected response", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R8/R7 error flag", int'(rsp_err), int'(e[8]));
                    if (e[9]) chk("R6/R7 response data", int'(rsp_rdata), int'(e[7:0]));
                    if (e[8]) chk("R8 earliest timeout", int'((cyc - accept_cyc) >= TO), 1);
                end
            end
            if (!mem_ce_n && cmd_ready) ready_busy_viol <= ready_busy_viol + 1;
            // write strobe
            if (p_we && !mem_we_n) begin
                chk("R3 oe high before strobe", int'(p_oe), 1);
                chk("R3 data driven before strobe", int'(p_dqoe), 1);
                strobe_addr <= mem_addr;
                we_run <= 1;
            end else if (!mem_we_n) begin
                we_run <= we_run + 1;
            end
            if (!p_we && mem_we_n) begin
                chk("R2 strobe width", we_run, WE_LOW);
                chk("R2 address stable", int'(mem_addr), int'(strobe_addr));
                in_hold <= 1'b1;
                hold_run <= 1;
            end else if (in_hold && mem_dq_oe) begin
                hold_run <= hold_run + 1;
            end else if (in_hold) begin
                chk("R4 hold length", hold_run, HOLD);
                in_hold <= 1'b0;
            end
            // read accesses
            if (p_oe && !mem_oe_n) begin
                chk("R5 bus released before oe", int'(p_dqoe), 0);
                oe_run <= 1;
            end else if (!mem_oe_n) begin
                oe_run <= oe_run + 1;
                if (mem_dq_oe) chk("R5 contention", 1, 0);
            end
            if (!p_oe && mem_oe_n) chk("R6 read access length", oe_run, RD);
        end
        p_we   <= mem_we_n;
        p_oe   <= mem_oe_n;
        p_dqoe <= mem_dq_oe;
    end

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        if (cyc == WD_LIMIT) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- driver ----------------
    task automatic do_cmd(input logic wr, input logic [8:0] a, input logic [7:0] d,
                          input int blen, input logic exp_err);
        busy_len = blen;
        while (!cmd_ready) @(negedge clk);
        if (wr) begin
            shadow[a] = d;
            exp_q.push_back({!exp_err, exp_err, d});
        end else begin
            exp_q.push_back({1'b1, 1'b0, shadow[a]});
        end
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = a;
        cmd_wdata = d;
        accept_cyc = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i]    = 8'(i) ^ 8'h5A;
            shadow[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", int'(cmd_ready), 1);
        chk("R1 ce_n", int'(mem_ce_n), 1);
        chk("R1 we_n", int'(mem_we_n), 1);
        chk("R1 oe_n", int'(mem_oe_n), 1);
        chk("R1 dq_oe", int'(mem_dq_oe), 0);
        chk("R1 rsp_valid", int'(rsp_valid), 0);

        do_cmd(1'b1, 9'h1A5, 8'hC3, 40, 1'b0);     // R7 bit7 = 1
        do_cmd(1'b1, 9'h003, 8'h3C, 200, 1'b0);    // R7 bit7 = 0
        do_cmd(1'b0, 9'h1A5, 8'h00, 1, 1'b0);      // R6 read back
        do_cmd(1'b0, 9'h003, 8'h00, 1, 1'b0);
        do_cmd(1'b0, 9'h0FF, 8'h00, 1, 1'b0);      // R6 initial content
        do_cmd(1'b1, 9'h0FF, 8'h80, 1, 1'b0);      // R7 first poll matches
        do_cmd(1'b0, 9'h0FF, 8'h00, 1, 1'b0);

        stuck = 1'b1;                              // R8 device never finishes
        do_cmd(1'b1, 9'h010, 8'h7F, 20, 1'b1);
        stuck = 1'b0;
        repeat (40) @(negedge clk);
        do_cmd(1'b0, 9'h010, 8'h00, 1, 1'b0);      // R8 pending byte still lands

        do_cmd(1'b1, 9'h1FF, 8'h00, 500, 1'b0);
        do_cmd(1'b0, 9'h1FF, 8'h00, 1, 1'b0);

        chk("R3 model saw driven data", int'(dq_seen), 1);
        chk("R9 ready low while busy", ready_busy_viol, 0);
        chk("R10 no pending responses", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule